// File: doc/BRIEF.md
# Keyed XOR Message Link

This block holds both ends of a short secure link. Each end has its own copy of a layered network of small lookup tables. A 32-bit key parameter fixes each copy's table contents and its wiring. On the sending end, a seed and a message word are taken together. The network output for that seed becomes a pad, and the pad is XORed into the message. The sender then offers the seed, unchanged, together with the masked word. The receiving end takes that pair and evaluates its own copy of the network on the seed. It XORs the resulting pad back out of the masked word to deliver the message.

Both ends recover the message only when they are built with the same key. Each end moves through three states: idle, evaluate, then hand off. An end accepts nothing new until its hand-off completes, so each word is processed in two clock edges. Every port group uses a valid/ready handshake.

Top module: `xor_mask_link`

## Requirements
- R1: While reset is held, the block comes up idle: `in_ready` and `rx_ready` are 1, and `lk_valid` and `out_valid` are 0.
- R2: A word is accepted at a clock edge where `in_valid` and `in_ready` are both 1. `lk_valid` rises at the second edge after that. At that point `lk_seed` equals the accepted seed.
- R3: While `lk_valid` is 1 and `lk_ready` is 0, `lk_seed` and `lk_masked` hold their values and `in_ready` stays 0. A transfer at the edge where `lk_valid` and `lk_ready` are both 1 returns the sender to idle.
- R4: When both keys are equal, `out_msg` equals the message that was sent with a seed, after the pair (`lk_seed`, `lk_masked`) is handed to (`rx_seed`, `rx_masked`).
- R5: The pad `lk_masked ^ message` depends only on the seed, for a fixed key. Two messages sent with the same seed give the same pad.
- R6: A pair is accepted at an edge where `rx_valid` and `rx_ready` are both 1. `out_valid` rises at the second edge after that. While `out_valid` is 1 and `out_ready` is 0, `out_msg` holds its value and `rx_ready` stays 0.
- R7: When the receive key differs from the send key, the message is not recovered. Over a run of many pairs, at most one pair comes out equal to the sent message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A seed and message word are offered to the sender |
| in_ready | output | 1 | Sender is idle and takes a word |
| in_seed | input | SEED_W | Seed for this word |
| in_msg | input | MSG_W | Plain message word |
| lk_valid | output | 1 | Seed and masked word are offered on the link |
| lk_ready | input | 1 | Link takes the pair |
| lk_seed | output | SEED_W | Seed, sent in the clear |
| lk_masked | output | MSG_W | Message XOR pad |
| rx_valid | input | 1 | A received pair is offered to the receiver |
| rx_ready | output | 1 | Receiver is idle and takes a pair |
| rx_seed | input | SEED_W | Received seed |
| rx_masked | input | MSG_W | Received masked word |
| out_valid | output | 1 | Recovered message is offered |
| out_ready | input | 1 | Consumer takes the message |
| out_msg | output | MSG_W | Recovered message |

## Verification
The bench builds the block with a 12-bit seed and a 16-bit message, so the network must index two different widths. It uses four levels of three-input tables, which is deep enough that most pad bits depend on several seed bits. A second instance is built with a different receive key, which makes the failed recovery of R7 observable.

The stimulus includes a repeated seed paired with two different messages, and all-zero and all-one messages. These cover the pad reuse of R5 and the XOR extremes.

// File: rtl/xor_mask_link.sv
module xor_mask_link #(
  parameter int SEED_W = 16,
  parameter int MSG_W = 16,
  parameter int DEPTH = 4,
  parameter int FANIN = 3,
  parameter logic [31:0] TX_KEY = 32'h5eed_c0de,
  parameter logic [31:0] RX_KEY = 32'h5eed_c0de
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEED_W-1:0] in_seed,
  input  logic [MSG_W-1:0]  in_msg,
  output logic              lk_valid,
  input  logic              lk_ready,
  output logic [SEED_W-1:0] lk_seed,
  output logic [MSG_W-1:0]  lk_masked,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [SEED_W-1:0] rx_seed,
  input  logic [MSG_W-1:0]  rx_masked,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MSG_W-1:0]  out_msg
);
  typedef enum logic [1:0] {IDLE = 2'd0, EVAL = 2'd1, HAND = 2'd2} st_t;

  function automatic logic [31:0] mix(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x >> 16);
    y = y * 32'h7feb_352d;
    y = y ^ (y >> 15);
    y = y * 32'h846c_a68b;
    y = y ^ (y >> 16);
    return y;
  endfunction

  st_t tx_st, rx_st;
  logic [SEED_W-1:0] tx_seed_q, rx_seed_q;
  logic [MSG_W-1:0]  tx_msg_q, rx_msg_q, tx_out_q, rx_out_q;
  logic [MSG_W-1:0]  tx_pad, rx_pad;

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam logic [31:0] KEY = (s == 0) ? TX_KEY : RX_KEY;
    logic [SEED_W-1:0] seed_v;
    assign seed_v = (s == 0) ? tx_seed_q : rx_seed_q;
    for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
      logic [MSG_W-1:0] o;
      for (genvar j = 0; j < MSG_W; j++) begin : g_lut
        localparam logic [31:0] TT = mix(KEY ^ (32'((l * MSG_W + j) * 2 + 1) * 32'h85eb_ca6b));
        logic [FANIN-1:0] sel;
        for (genvar p = 0; p < FANIN; p++) begin : g_pin
          localparam logic [31:0] HV = mix(KEY ^ (32'((l * MSG_W + j) * FANIN + p) * 32'h9e37_79b9));
          localparam int IDX_S = int'(HV[16:1]) % SEED_W;
          localparam int IDX_W = int'(HV[16:1]) % MSG_W;
          if (l == 0 || HV[0]) begin : g_seed
            assign sel[p] = seed_v[IDX_S];
          end else begin : g_prev
            assign sel[p] = g_lvl[l-1].o[IDX_W];
          end
        end
        assign o[j] = TT[sel];
      end
    end
    if (s == 0) begin : g_txo
      assign tx_pad = g_lvl[DEPTH-1].o;
    end else begin : g_rxo
      assign rx_pad = g_lvl[DEPTH-1].o;
    end
  end

  assign in_ready  = (tx_st == IDLE);
  assign lk_valid  = (tx_st == HAND);
  assign lk_seed   = tx_seed_q;
  assign lk_masked = tx_out_q;
  assign rx_ready  = (rx_st == IDLE);
  assign out_valid = (rx_st == HAND);
  assign out_msg   = rx_out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st <= IDLE;
      tx_seed_q <= '0;
      tx_msg_q <= '0;
      tx_out_q <= '0;
    end else begin
      case (tx_st)
        IDLE: if (in_valid) begin
          tx_seed_q <= in_seed;
          tx_msg_q <= in_msg;
          tx_st <= EVAL;
        end
        EVAL: begin
          tx_out_q <= tx_pad ^ tx_msg_q;
          tx_st <= HAND;
        end
        default: if (lk_ready) tx_st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st <= IDLE;
      rx_seed_q <= '0;
      rx_msg_q <= '0;
      rx_out_q <= '0;
    end else begin
      case (rx_st)
        IDLE: if (rx_valid) begin
          rx_seed_q <= rx_seed;
          rx_msg_q <= rx_masked;
          rx_st <= EVAL;
        end
        EVAL: begin
          rx_out_q <= rx_pad ^ rx_msg_q;
          rx_st <= HAND;
        end
        default: if (out_ready) rx_st <= IDLE;
      endcase
    end
  end
endmodule

module xor_mask_link_chk #(
  parameter int SEED_W = 16,
  parameter int MSG_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [SEED_W-1:0] lk_seed,
  input logic [MSG_W-1:0]  lk_masked,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [MSG_W-1:0]  out_msg
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (in_ready && rx_ready && !lk_valid && !out_valid));
  assert_send_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!lk_valid ##1 lk_valid));
  assert_link_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_ready) |=> (lk_valid && $stable(lk_seed) && $stable(lk_masked)));
  assert_tx_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> !in_ready);
  assert_recv_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (!out_valid ##1 out_valid));
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_msg)));
  assert_rx_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rx_ready);
endmodule

bind xor_mask_link xor_mask_link_chk #(.SEED_W(SEED_W), .MSG_W(MSG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_seed(lk_seed), .lk_masked(lk_masked),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_msg(out_msg)
);

// File: tb/tb_xor_mask_link.sv
module tb_xor_mask_link;
  localparam int SW = 12;
  localparam int MW = 16;
  localparam int NV = 8;
  localparam int NR = 120;
  localparam logic [SW+MW-1:0] VEC [NV] = '{
    {12'h0a5, 16'h1234}, {12'h000, 16'h0000}, {12'hfff, 16'hffff}, {12'h3c3, 16'hbeef},
    {12'h0a5, 16'hffff}, {12'h801, 16'h0001}, {12'h5a5, 16'h8000}, {12'h001, 16'hc0de}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, lk_ready = 0, rx_valid = 0, out_ready = 0;
  logic [SW-1:0] in_seed = '0, rx_seed = '0;
  logic [MW-1:0] in_msg = '0, rx_masked = '0;
  logic in_ready, lk_valid, rx_ready, out_valid;
  logic [SW-1:0] lk_seed;
  logic [MW-1:0] lk_masked, out_msg;
  logic b_in_ready, b_lk_valid, b_rx_ready, b_out_valid;
  logic [SW-1:0] b_lk_seed;
  logic [MW-1:0] b_lk_masked, b_out_msg;
  int errors = 0, checks = 0, bad_hits = 0, cyc = 0;
  logic [MW-1:0] pads [NV];

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1; checks = checks + 1;
      $display("FAIL watchdog: actual cycles=%0d expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  xor_mask_link #(.SEED_W(SW), .MSG_W(MW), .DEPTH(4), .FANIN(3)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_seed(in_seed),
    .in_msg(in_msg), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_seed(lk_seed),
    .lk_masked(lk_masked), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_seed(rx_seed),
    .rx_masked(rx_masked), .out_valid(out_valid), .out_ready(out_ready), .out_msg(out_msg));

  xor_mask_link #(.SEED_W(SW), .MSG_W(MW), .DEPTH(4), .FANIN(3), .RX_KEY(32'h0bad_5eed)) dut_bad (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(b_in_ready), .in_seed(in_seed),
    .in_msg(in_msg), .lk_valid(b_lk_valid), .lk_ready(lk_ready), .lk_seed(b_lk_seed),
    .lk_masked(b_lk_masked), .rx_valid(rx_valid), .rx_ready(b_rx_ready), .rx_seed(rx_seed),
    .rx_masked(rx_masked), .out_valid(b_out_valid), .out_ready(out_ready), .out_msg(b_out_msg));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [SW-1:0] s, input logic [MW-1:0] m, input bit detail,
                     output logic [MW-1:0] pad);
    int lat;
    logic [MW-1:0] held;
    @(negedge clk);
    in_valid = 1; in_seed = s; in_msg = m;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    lat = 1;
    while (!lk_valid && lat < 10) begin @(negedge clk); lat++; end
    if (detail) begin
      check(lat == 2, "R2 latency", lat, 2);
      check(lk_seed == s, "R2 seed", lk_seed, s);
    end
    held = lk_masked;
    @(negedge clk);
    if (detail) begin
      check(lk_valid && lk_masked == held && lk_seed == s, "R3 hold", lk_masked, held);
      check(!in_ready, "R3 busy", in_ready, 0);
    end
    pad = lk_masked ^ m;
    rx_seed = lk_seed; rx_masked = lk_masked; lk_ready = 1;
    @(negedge clk);
    lk_ready = 0;
    if (detail) check(!lk_valid && in_ready, "R3 release", lk_valid, 0);
    rx_valid = 1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 0;
    lat = 1;
    while (!out_valid && lat < 10) begin @(negedge clk); lat++; end
    if (detail) check(lat == 2, "R6 latency", lat, 2);
    held = out_msg;
    @(negedge clk);
    if (detail) begin
      check(out_valid && out_msg == held, "R6 hold", out_msg, held);
      check(!rx_ready, "R6 busy", rx_ready, 0);
    end
    check(out_msg == m, "R4 recover", out_msg, m);
    if (b_out_msg == m) bad_hits++;
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  initial begin
    logic [MW-1:0] p;
    repeat (3) @(negedge clk);
    check(in_ready && rx_ready && !lk_valid && !out_valid, "R1 reset",
          {in_ready, rx_ready, lk_valid, out_valid}, 4'b1100);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      run(VEC[i][SW+MW-1:MW], VEC[i][MW-1:0], 1'b1, p);
      pads[i] = p;
    end
    check(pads[0] == pads[4], "R5 same seed pad", pads[4], pads[0]);
    for (int i = 0; i < NR; i++) begin
      logic [SW-1:0] s;
      logic [MW-1:0] m;
      s = SW'($urandom);
      m = MW'($urandom);
      run(s, m, (i % 20) == 0, p);
    end
    check(bad_hits <= 1, "R7 mismatched key", bad_hits, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule